// File: doc/BRIEF.md
# Command Ring Wrap and Buffer Aging Controller

This block sits on the producer side of a circular command ring that a DMA engine drains. It keeps the write tail, works out the free space from the tail and the engine's read head, and compares that space against a high-water mark. Each flush request either hands the current tail to the engine or starts a wrap. A started wrap stays pending until a submission finds the engine idle and closes it. Closing a wrap rewinds the tail to offset zero and bumps a wrap counter.

Submissions come in two kinds. A non-blocking submission answers at once. A blocking submission may wait for the engine to go idle, up to a bounded number of cycles. Each answer is a one-cycle response that is either accepted or busy. The block also stamps released buffers with an age made of a wrap count and an absolute head address. A later query tells whether a stamped buffer has been consumed and may be reused.

Top module: `cmdring_wrap_ctl`

## Requirements
- R1: After reset the tail is 0, the wrap count is 0, no wrap is pending, and no flush, wrap-start or response pulse is raised.
- R2: The engine counts as idle only when bits 0, 16 and 17 of the status word, taken together, equal exactly bit 17 set. All other status bits are ignored.
- R3: Each cycle with `blk_push` high advances the tail by one 20-byte command block. Free space is RING_BYTES minus (tail minus head) when the head is not above the tail, and head minus tail otherwise. It follows the head input in the same cycle.
- R4: A flush request with no wrap pending and free space at or above HIGH_MARK raises `flush_o` for one cycle, one cycle later, with `flush_tail_o` equal to the tail.
- R5: A flush request with no wrap pending and free space below HIGH_MARK raises `wrap_start_o` for one cycle and sets the pending flag. No flush is issued.
- R6: A flush request while a wrap is pending raises neither `flush_o` nor `wrap_start_o`.
- R7: A submission of either kind with no wrap pending is answered one cycle later with `resp_valid_o` high and `resp_busy_o` low.
- R8: A non-blocking submission during a pending wrap behaves as follows. If the engine is idle, it completes the wrap and is accepted. If the engine is not idle and free space is below HIGH_MARK, it is answered busy. Otherwise it is accepted and the wrap stays pending.
- R9: A blocking submission during a pending wrap waits for idle. If the engine becomes idle, the wrap completes and the submission is accepted. If TIMEOUT cycles pass without idle, it is answered busy with the wrap still pending, TIMEOUT+1 cycles after the request.
- R10: Completing a wrap sets the tail to 0, increments the wrap count and clears the pending flag.
- R11: A stamp request for a dispatched buffer returns, one cycle later, head = tail + `ring_base` and wrap = the current wrap count. For a buffer never dispatched it returns head 0 and wrap 0.
- R12: A retire query returns, one cycle later, retired = 1 when the queried wrap is less than the current wrap count, or when the wraps are equal and the queried head is less than `rd_head + ring_base`. Otherwise it returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_push | input | 1 | One command block written this cycle |
| flush_req | input | 1 | Request to hand queued work to the engine |
| sub_req | input | 1 | Submission request |
| sub_blocking | input | 1 | 1 = blocking submission, 0 = non-blocking |
| rd_head | input | OFF_W | Engine read offset within the ring |
| eng_status | input | 32 | Engine status word |
| ring_base | input | ADDR_W | Absolute base address of the ring |
| stamp_req | input | 1 | Stamp a released buffer |
| stamp_disp | input | 1 | Buffer being stamped was dispatched |
| chk_req | input | 1 | Retire query |
| chk_wrap | input | WRAP_W | Wrap part of the queried age |
| chk_head | input | ADDR_W | Head part of the queried age |
| tail_o | output | OFF_W | Current tail offset |
| free_o | output | OFF_W | Current free space in bytes |
| idle_o | output | 1 | Engine idle decode |
| wrap_pend_o | output | 1 | Wrap pending flag |
| wrap_cnt_o | output | WRAP_W | Completed wrap count |
| flush_o | output | 1 | One-cycle flush pulse |
| flush_tail_o | output | OFF_W | Tail handed over with the flush |
| wrap_start_o | output | 1 | One-cycle wrap-start pulse |
| resp_valid_o | output | 1 | Submission answered |
| resp_busy_o | output | 1 | Answer is busy |
| stamp_valid_o | output | 1 | Stamp result valid |
| stamp_head_o | output | ADDR_W | Stamped head address |
| stamp_wrap_o | output | WRAP_W | Stamped wrap count |
| chk_valid_o | output | 1 | Retire result valid |
| chk_retired_o | output | 1 | Queried buffer is retired |

## Verification
The bench goes after several corner cases. One is the non-blocking submission that arrives during a pending wrap while the engine is busy but with space above the mark. A design that ignored the space test would refuse it, or would close the wrap early and rewind the tail under a running engine. Another is the blocking timeout, which is timed to the exact cycle: an off-by-one counter would answer a cycle early or late, or would never answer. The idle decode is tested with an unrelated status bit set and with the soft-trap bit set; a loose mask would report idle with a trap outstanding. The retire query is tested at equal head and wrap, where a less-or-equal compare would free a buffer the engine has not yet passed.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;
   localparam int BLK_BYTES = 20;
   localparam logic [31:0] IDLE_MASK  = 32'h0003_0001;
   localparam logic [31:0] IDLE_MATCH = 32'h0002_0000;

   typedef enum logic [0:0] {CR_RUN = 1'b0, CR_WAIT = 1'b1} cr_state_e;

   function automatic logic status_idle(input logic [31:0] st);
      return (st & IDLE_MASK) == IDLE_MATCH;
   endfunction
endpackage

// File: rtl/cmdring_space.sv
module cmdring_space #(
   parameter int RING_BYTES = 200,
   parameter int HIGH_MARK  = 60,
   parameter int OFF_W      = 8
) (
   input  logic [OFF_W-1:0] tail,
   input  logic [OFF_W-1:0] head,
   output logic [OFF_W-1:0] free_sp,
   output logic             low
);
   localparam logic [OFF_W-1:0] RING_L = OFF_W'(RING_BYTES);
   localparam logic [OFF_W-1:0] MARK_L = OFF_W'(HIGH_MARK);

   always_comb begin
      if (head > tail) free_sp = head - tail;
      else             free_sp = RING_L - (tail - head);
      low = free_sp < MARK_L;
   end
endmodule

// File: rtl/cmdring_seq.sv
module cmdring_seq
   import cmdring_pkg::*;
#(
   parameter int OFF_W   = 8,
   parameter int WRAP_W  = 8,
   parameter int TIMEOUT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              blk_push,
   input  logic              flush_req,
   input  logic              sub_req,
   input  logic              sub_blocking,
   input  logic              idle,
   input  logic              low,
   output logic [OFF_W-1:0]  tail_q,
   output logic [WRAP_W-1:0] wrap_q,
   output logic              pend_q,
   output logic              flush_q,
   output logic [OFF_W-1:0]  flush_tail_q,
   output logic              wstart_q,
   output logic              rv_q,
   output logic              rb_q
);
   localparam int TMO_W = $clog2(TIMEOUT + 1);

   cr_state_e        st_q, st_n;
   logic [TMO_W-1:0] cnt_q, cnt_n;
   logic             pend_n, done, rv, rb, fl, ws;
   logic [OFF_W-1:0] tail_n;

   always_comb begin
      st_n   = st_q;
      cnt_n  = cnt_q;
      pend_n = pend_q;
      done   = 1'b0;
      rv     = 1'b0;
      rb     = 1'b0;
      fl     = 1'b0;
      ws     = 1'b0;
      case (st_q)
         CR_RUN: begin
            if (sub_req) begin
               if (!pend_q) rv = 1'b1;
               else if (idle) begin
                  done = 1'b1;
                  rv   = 1'b1;
               end else if (!sub_blocking) begin
                  rv = 1'b1;
                  rb = low;
               end else begin
                  st_n  = CR_WAIT;
                  cnt_n = '0;
               end
            end else if (flush_req && !pend_q) begin
               if (low) begin
                  ws     = 1'b1;
                  pend_n = 1'b1;
               end else fl = 1'b1;
            end
         end
         CR_WAIT: begin
            if (idle) begin
               done = 1'b1;
               rv   = 1'b1;
               st_n = CR_RUN;
            end else if (cnt_q == TMO_W'(TIMEOUT - 1)) begin
               rv   = 1'b1;
               rb   = 1'b1;
               st_n = CR_RUN;
            end else cnt_n = cnt_q + 1'b1;
         end
         default: st_n = CR_RUN;
      endcase
      if (done) pend_n = 1'b0;
      if (done)          tail_n = '0;
      else if (blk_push) tail_n = tail_q + OFF_W'(BLK_BYTES);
      else               tail_n = tail_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q         <= CR_RUN;
         cnt_q        <= '0;
         pend_q       <= 1'b0;
         tail_q       <= '0;
         wrap_q       <= '0;
         flush_q      <= 1'b0;
         flush_tail_q <= '0;
         wstart_q     <= 1'b0;
         rv_q         <= 1'b0;
         rb_q         <= 1'b0;
      end else begin
         st_q     <= st_n;
         cnt_q    <= cnt_n;
         pend_q   <= pend_n;
         tail_q   <= tail_n;
         flush_q  <= fl;
         wstart_q <= ws;
         rv_q     <= rv;
         rb_q     <= rb;
         if (fl)   flush_tail_q <= tail_q;
         if (done) wrap_q <= wrap_q + 1'b1;
      end
   end
endmodule

// File: rtl/cmdring_age.sv
module cmdring_age #(
   parameter int OFF_W  = 8,
   parameter int WRAP_W = 8,
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OFF_W-1:0]  tail,
   input  logic [OFF_W-1:0]  rd_head,
   input  logic [WRAP_W-1:0] wrap_cnt,
   input  logic [ADDR_W-1:0] ring_base,
   input  logic              stamp_req,
   input  logic              stamp_disp,
   input  logic              chk_req,
   input  logic [WRAP_W-1:0] chk_wrap,
   input  logic [ADDR_W-1:0] chk_head,
   output logic              stamp_valid,
   output logic [ADDR_W-1:0] stamp_head,
   output logic [WRAP_W-1:0] stamp_wrap,
   output logic              chk_valid,
   output logic              chk_retired
);
   logic [ADDR_W-1:0] abs_tail, abs_head;
   logic              older;

   always_comb begin
      abs_tail = ring_base + ADDR_W'(tail);
      abs_head = ring_base + ADDR_W'(rd_head);
      older    = (chk_wrap < wrap_cnt) ||
                 ((chk_wrap == wrap_cnt) && (chk_head < abs_head));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stamp_valid <= 1'b0;
         stamp_head  <= '0;
         stamp_wrap  <= '0;
         chk_valid   <= 1'b0;
         chk_retired <= 1'b0;
      end else begin
         stamp_valid <= stamp_req;
         chk_valid   <= chk_req;
         if (stamp_req) begin
            stamp_head <= stamp_disp ? abs_tail : '0;
            stamp_wrap <= stamp_disp ? wrap_cnt : '0;
         end
         if (chk_req) chk_retired <= older;
      end
   end
endmodule

// File: rtl/cmdring_wrap_ctl.sv
module cmdring_wrap_ctl
   import cmdring_pkg::*;
#(
   parameter int  RING_BYTES = 200,
   parameter int  HIGH_MARK  = 60,
   parameter int  WRAP_W     = 8,
   parameter int  ADDR_W     = 32,
   parameter int  TIMEOUT    = 16,
   localparam int OFF_W      = $clog2(RING_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              blk_push,
   input  logic              flush_req,
   input  logic              sub_req,
   input  logic              sub_blocking,
   input  logic [OFF_W-1:0]  rd_head,
   input  logic [31:0]       eng_status,
   input  logic [ADDR_W-1:0] ring_base,
   input  logic              stamp_req,
   input  logic              stamp_disp,
   input  logic              chk_req,
   input  logic [WRAP_W-1:0] chk_wrap,
   input  logic [ADDR_W-1:0] chk_head,
   output logic [OFF_W-1:0]  tail_o,
   output logic [OFF_W-1:0]  free_o,
   output logic              idle_o,
   output logic              wrap_pend_o,
   output logic [WRAP_W-1:0] wrap_cnt_o,
   output logic              flush_o,
   output logic [OFF_W-1:0]  flush_tail_o,
   output logic              wrap_start_o,
   output logic              resp_valid_o,
   output logic              resp_busy_o,
   output logic              stamp_valid_o,
   output logic [ADDR_W-1:0] stamp_head_o,
   output logic [WRAP_W-1:0] stamp_wrap_o,
   output logic              chk_valid_o,
   output logic              chk_retired_o
);
   if (RING_BYTES % BLK_BYTES != 0) begin : g_bad_ring
      $error("RING_BYTES must be a whole number of command blocks");
   end
   if (HIGH_MARK < 1 || HIGH_MARK > RING_BYTES) begin : g_bad_mark
      $error("HIGH_MARK must lie within the ring");
   end
   if (TIMEOUT < 1) begin : g_bad_tmo
      $error("TIMEOUT must be at least one cycle");
   end
   if (ADDR_W < OFF_W) begin : g_bad_addr
      $error("ADDR_W must cover the ring offset");
   end

   logic low;

   assign idle_o = status_idle(eng_status);

   cmdring_space #(
      .RING_BYTES(RING_BYTES), .HIGH_MARK(HIGH_MARK), .OFF_W(OFF_W)
   ) i_space (
      .tail(tail_o), .head(rd_head), .free_sp(free_o), .low(low)
   );

   cmdring_seq #(
      .OFF_W(OFF_W), .WRAP_W(WRAP_W), .TIMEOUT(TIMEOUT)
   ) i_seq (
      .clk(clk), .rst_n(rst_n), .blk_push(blk_push), .flush_req(flush_req),
      .sub_req(sub_req), .sub_blocking(sub_blocking), .idle(idle_o), .low(low),
      .tail_q(tail_o), .wrap_q(wrap_cnt_o), .pend_q(wrap_pend_o),
      .flush_q(flush_o), .flush_tail_q(flush_tail_o), .wstart_q(wrap_start_o),
      .rv_q(resp_valid_o), .rb_q(resp_busy_o)
   );

   cmdring_age #(
      .OFF_W(OFF_W), .WRAP_W(WRAP_W), .ADDR_W(ADDR_W)
   ) i_age (
      .clk(clk), .rst_n(rst_n), .tail(tail_o), .rd_head(rd_head),
      .wrap_cnt(wrap_cnt_o), .ring_base(ring_base), .stamp_req(stamp_req),
      .stamp_disp(stamp_disp), .chk_req(chk_req), .chk_wrap(chk_wrap),
      .chk_head(chk_head), .stamp_valid(stamp_valid_o), .stamp_head(stamp_head_o),
      .stamp_wrap(stamp_wrap_o), .chk_valid(chk_valid_o), .chk_retired(chk_retired_o)
   );
endmodule

// File: rtl/cmdring_wrap_ctl_chk.sv
module cmdring_wrap_ctl_chk #(
   parameter int OFF_W  = 8,
   parameter int WRAP_W = 8,
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [OFF_W-1:0]  tail_o,
   input logic              wrap_pend_o,
   input logic [WRAP_W-1:0] wrap_cnt_o,
   input logic              flush_o,
   input logic              wrap_start_o,
   input logic              resp_valid_o,
   input logic              resp_busy_o,
   input logic              stamp_disp,
   input logic              stamp_valid_o,
   input logic [ADDR_W-1:0] stamp_head_o,
   input logic [WRAP_W-1:0] stamp_wrap_o,
   input logic [WRAP_W-1:0] chk_wrap,
   input logic              chk_valid_o,
   input logic              chk_retired_o
);
   a_r5_start_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_start_o |-> wrap_pend_o);

   a_r6_no_flush_when_pend: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |-> !$past(wrap_pend_o));

   a_r4_flush_or_start: assert property (@(posedge clk) disable iff (!rst_n)
      !(flush_o && wrap_start_o));

   a_r8_busy_in_resp: assert property (@(posedge clk) disable iff (!rst_n)
      resp_busy_o |-> resp_valid_o);

   a_r10_wrap_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wrap_pend_o) |-> (tail_o == '0));

   a_r10_wrap_step: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_cnt_o != $past(wrap_cnt_o)) |->
         ((wrap_cnt_o == $past(wrap_cnt_o) + 1'b1) && $fell(wrap_pend_o)));

   a_r3_tail_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(tail_o) % 20) == 0);

   a_r11_undisp_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (stamp_valid_o && !$past(stamp_disp)) |-> (stamp_head_o == '0 && stamp_wrap_o == '0));

   a_r12_older_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid_o && ($past(chk_wrap) < $past(wrap_cnt_o))) |-> chk_retired_o);
endmodule

bind cmdring_wrap_ctl cmdring_wrap_ctl_chk #(
   .OFF_W(OFF_W), .WRAP_W(WRAP_W), .ADDR_W(ADDR_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .tail_o(tail_o), .wrap_pend_o(wrap_pend_o),
   .wrap_cnt_o(wrap_cnt_o), .flush_o(flush_o), .wrap_start_o(wrap_start_o),
   .resp_valid_o(resp_valid_o), .resp_busy_o(resp_busy_o), .stamp_disp(stamp_disp),
   .stamp_valid_o(stamp_valid_o), .stamp_head_o(stamp_head_o),
   .stamp_wrap_o(stamp_wrap_o), .chk_wrap(chk_wrap), .chk_valid_o(chk_valid_o),
   .chk_retired_o(chk_retired_o)
);

// File: tb/test_cmdring_wrap_ctl.sv
module test_cmdring_wrap_ctl;
   localparam int RING = 200;
   localparam int MARK = 60;
   localparam int TMO  = 16;
   localparam int OW   = 8;
   localparam int WW   = 8;
   localparam int AW   = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic blk_push = 0, flush_req = 0, sub_req = 0, sub_blocking = 0;
   logic [OW-1:0] rd_head = '0;
   logic [31:0]   eng_status = '0;
   logic [AW-1:0] ring_base = '0;
   logic stamp_req = 0, stamp_disp = 0, chk_req = 0;
   logic [WW-1:0] chk_wrap = '0;
   logic [AW-1:0] chk_head = '0;
   logic [OW-1:0] tail_o, free_o, flush_tail_o;
   logic idle_o, wrap_pend_o, flush_o, wrap_start_o, resp_valid_o, resp_busy_o;
   logic [WW-1:0] wrap_cnt_o, stamp_wrap_o;
   logic stamp_valid_o, chk_valid_o, chk_retired_o;
   logic [AW-1:0] stamp_head_o;

   int checks = 0, fails = 0;
   int cyc = 0, sub_cyc = 0, resp_cyc = 0;
   bit exp_q[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   cmdring_wrap_ctl #(
      .RING_BYTES(RING), .HIGH_MARK(MARK), .WRAP_W(WW), .ADDR_W(AW), .TIMEOUT(TMO)
   ) i_cmdring_wrap_ctl (
      .clk(clk), .rst_n(rst_n), .blk_push(blk_push), .flush_req(flush_req),
      .sub_req(sub_req), .sub_blocking(sub_blocking), .rd_head(rd_head),
      .eng_status(eng_status), .ring_base(ring_base), .stamp_req(stamp_req),
      .stamp_disp(stamp_disp), .chk_req(chk_req), .chk_wrap(chk_wrap),
      .chk_head(chk_head), .tail_o(tail_o), .free_o(free_o), .idle_o(idle_o),
      .wrap_pend_o(wrap_pend_o), .wrap_cnt_o(wrap_cnt_o), .flush_o(flush_o),
      .flush_tail_o(flush_tail_o), .wrap_start_o(wrap_start_o),
      .resp_valid_o(resp_valid_o), .resp_busy_o(resp_busy_o),
      .stamp_valid_o(stamp_valid_o), .stamp_head_o(stamp_head_o),
      .stamp_wrap_o(stamp_wrap_o), .chk_valid_o(chk_valid_o),
      .chk_retired_o(chk_retired_o)
   );

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic push(input int n);
      blk_push = 1;
      repeat (n) step();
      blk_push = 0;
   endtask

   task automatic flush();
      flush_req = 1;
      step();
      flush_req = 0;
   endtask

   task automatic submit(input bit blocking, input bit exp_busy);
      exp_q.push_back(exp_busy);
      sub_req = 1;
      sub_blocking = blocking;
      sub_cyc = cyc;
      step();
      sub_req = 0;
   endtask

   // scoreboard monitor for submission responses
   always @(negedge clk) begin
      if (rst_n && resp_valid_o) begin
         resp_cyc = cyc;
         if (exp_q.size() == 0) begin
            checks++;
            fails++;
            $display("FAIL R7 unexpected response actual=1 expected=0");
         end else check("R8/R9 response busy", resp_busy_o, exp_q.pop_front());
      end
   end

   initial begin
      #(4 * 100000);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) step();
      rst_n = 1;
      step();
      // R1 reset state
      check("R1 tail", tail_o, 0);
      check("R1 wrap", wrap_cnt_o, 0);
      check("R1 pend", wrap_pend_o, 0);
      check("R1 pulses", {flush_o, wrap_start_o, resp_valid_o}, 0);
      check("R3 free empty", free_o, RING);

      // R2 idle decode
      eng_status = 32'h0002_0000; #1 check("R2 idle", idle_o, 1);
      eng_status = 32'h0002_0001; #1 check("R2 trap", idle_o, 0);
      eng_status = 32'h0003_0000; #1 check("R2 drawing", idle_o, 0);
      eng_status = 32'h0000_0000; #1 check("R2 no end", idle_o, 0);
      eng_status = 32'hF0F2_0020; #1 check("R2 other bits", idle_o, 1);
      eng_status = 32'h0;

      // R3 tail and free space
      push(3);
      check("R3 tail", tail_o, 60);
      check("R3 free", free_o, 140);
      rd_head = 40;  #1 check("R3 free head below", free_o, 180);
      rd_head = 100; #1 check("R3 free head above", free_o, 40);
      rd_head = 0;   #1;

      // R4 normal flush
      flush();
      check("R4 flush", flush_o, 1);
      check("R4 flush tail", flush_tail_o, 60);
      check("R4 no start", wrap_start_o, 0);
      step();
      check("R4 one cycle", flush_o, 0);

      // R7 submit with no wrap pending
      submit(0, 0);
      check("R7 response at once", resp_valid_o, 1);
      submit(1, 0);
      step();

      // R5 wrap start
      push(5);
      check("R5 tail", tail_o, 160);
      flush();
      check("R5 start", wrap_start_o, 1);
      check("R5 no flush", flush_o, 0);
      check("R5 pend", wrap_pend_o, 1);

      // R6 flush ignored while pending
      flush();
      check("R6 no flush", flush_o, 0);
      check("R6 no start", wrap_start_o, 0);

      // R8 non-blocking, busy engine, low space -> busy
      submit(0, 1);
      step();
      check("R8 still pend", wrap_pend_o, 1);
      // R8 non-blocking, busy engine, enough space -> accepted, pending kept
      rd_head = 150; #1;
      check("R3 free near", free_o, 190);
      submit(0, 0);
      step();
      check("R8 pend kept", wrap_pend_o, 1);
      check("R8 tail kept", tail_o, 160);
      rd_head = 0;
      // R8 idle completes the wrap
      eng_status = 32'h0002_0000;
      submit(0, 0);
      check("R10 tail rewind", tail_o, 0);
      check("R10 wrap count", wrap_cnt_o, 1);
      check("R10 pend clear", wrap_pend_o, 0);
      check("R10 free full", free_o, RING);
      eng_status = 32'h0;

      // R11 stamps
      push(2);
      ring_base = 32'h1000;
      stamp_req = 1; stamp_disp = 1;
      step();
      stamp_req = 0; stamp_disp = 0;
      check("R11 valid", stamp_valid_o, 1);
      check("R11 head", stamp_head_o, 32'h1028);
      check("R11 wrap", stamp_wrap_o, 1);
      stamp_req = 1;
      step();
      stamp_req = 0;
      check("R11 undispatched head", stamp_head_o, 0);
      check("R11 undispatched wrap", stamp_wrap_o, 0);

      // R12 retire queries, current wrap 1, abs head 0x100A
      rd_head = 10;
      chk_req = 1;
      chk_wrap = 0; chk_head = 32'hFFFF; step();
      check("R12 older wrap", chk_retired_o, 1);
      chk_wrap = 1; chk_head = 32'h1000; step();
      check("R12 head below", chk_retired_o, 1);
      chk_wrap = 1; chk_head = 32'h100A; step();
      check("R12 head equal", chk_retired_o, 0);
      chk_wrap = 2; chk_head = 32'h0; step();
      check("R12 newer wrap", chk_retired_o, 0);
      chk_req = 0;
      check("R12 valid", chk_valid_o, 1);
      rd_head = 0;

      // R9 blocking timeout
      push(6);
      check("R9 tail", tail_o, 160);
      flush();
      check("R9 pend", wrap_pend_o, 1);
      submit(1, 1);
      repeat (TMO + 2) step();
      check("R9 timeout latency", resp_cyc - sub_cyc, TMO + 1);
      check("R9 pend after timeout", wrap_pend_o, 1);
      check("R9 wrap unchanged", wrap_cnt_o, 1);

      // R9 blocking sees idle after a wait
      submit(1, 0);
      repeat (3) step();
      check("R9 waiting", wrap_pend_o, 1);
      eng_status = 32'h0002_0000;
      step();
      check("R9 done tail", tail_o, 0);
      check("R9 done wrap", wrap_cnt_o, 2);
      check("R9 done pend", wrap_pend_o, 0);
      eng_status = 32'h0;
      step();
      step();
      check("R7 queue drained", exp_q.size(), 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule